// File: doc/BRIEF.md
# Immediate-Shift Operand Barrel Shifter

This block forms the second operand of a data-processing or load/store instruction whose shift amount is an immediate field. It pulls the shift kind, the 5-bit amount and the source register index out of the 32-bit instruction word. It applies that shift to a register value supplied by the caller and returns the shifted value together with a shifter carry-out. The incoming carry flag is an input. The block does not own the flag register. Instead, an enable output tells the caller whether the carry should be written back.

An amount of zero is re-encoded for three of the four shift kinds. On a left shift it means pass-through. On the two right shifts it means a full 32-bit shift. On a rotate it means a one-place rotate through the carry.

An optional offset stage, chosen by a parameter, turns the shifted value or a 12-bit literal into a memory offset. It then adds that offset to a base value or subtracts it, under an up/down bit. All results are registered once.

Top module: `shf_operand_unit`

## Requirements
- R1: The shift kind is instruction bits [6:5] (0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right) and the amount n is bits [11:7]. Bits [3:0] appear unchanged on `rm_idx_o`.
- R2: For n from 1 to 31, the result is the operand shifted by n places. Logical shifts fill with zeros, the arithmetic right shift fills with operand bit 31, and the rotate right moves the bits shifted out at bit 0 back in at bit 31.
- R3: For n from 1 to 31, the carry-out is as follows. A left shift gives operand bit (32-n). Either right shift gives operand bit (n-1). A rotate gives result bit 31.
- R4: A logical left shift with n = 0 returns the operand unchanged, with carry-out equal to `carry_i` and `carry_we_o` = 0.
- R5: A logical right shift with n = 0 returns zero, with carry-out equal to operand bit 31.
- R6: An arithmetic right shift with n = 0 returns 32 copies of operand bit 31, with carry-out equal to operand bit 31.
- R7: A rotate right with n = 0 returns the operand shifted right by one with `carry_i` in bit 31, and carry-out equals operand bit 0.
- R8: `carry_we_o` is 1 for every case except the one in R4.
- R9: The offset is the shifted result when instruction bit 25 is 0, and the zero-extended bits [11:0] when bit 25 is 1. `addr_o` is base plus offset when bit 23 is 1, and base minus offset when bit 23 is 0.
- R10: Every output is registered and reflects the inputs sampled at the previous rising clock edge. While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| instr_i | input | 32 | Instruction word |
| operand_i | input | 32 | Register value to shift |
| carry_i | input | 1 | Current carry flag |
| base_i | input | 32 | Base value for the offset stage |
| result_o | output | 32 | Shifted operand |
| carry_o | output | 1 | Shifter carry-out |
| carry_we_o | output | 1 | Carry write-back enable |
| addr_o | output | 32 | Base adjusted by the offset |
| rm_idx_o | output | 4 | Source register index |

## Verification
Each output is due at the first rising edge after its inputs are applied, which is one register stage with no other delay. The bench drives its inputs on a falling edge. The following rising edge captures them, and the bench compares the outputs at the next falling edge, half a period after that capture. The checker properties look back one cycle with `$past` to the inputs that produced each registered value. A property only applies when the previous cycle was also out of reset.

// File: rtl/shf_pkg.sv
package shf_pkg;

    typedef enum logic [1:0] {
        SHK_LSL = 2'd0,
        SHK_LSR = 2'd1,
        SHK_ASR = 2'd2,
        SHK_ROR = 2'd3
    } shk_e;

    localparam int unsigned KIND_LO  = 5;
    localparam int unsigned AMT_LO   = 7;
    localparam int unsigned AMT_BITS = 5;
    localparam int unsigned IDX_BITS = 4;
    localparam int unsigned LIT_BITS = 12;
    localparam int unsigned UP_BIT   = 23;
    localparam int unsigned IMM_BIT  = 25;

    typedef struct packed {
        shk_e                  kind;
        logic [AMT_BITS-1:0]   amt;
        logic [IDX_BITS-1:0]   rm;
        logic [LIT_BITS-1:0]   lit;
        logic                  up;
        logic                  lit_sel;
    } shf_fields_t;

endpackage

// File: rtl/shf_decode.sv
module shf_decode
    import shf_pkg::*;
#(
    parameter int unsigned INSN_W = 32
) (
    input  logic [INSN_W-1:0] instr_i,
    output shf_fields_t       fields_o
);
    always_comb begin
        fields_o.kind    = shk_e'(instr_i[KIND_LO +: 2]);
        fields_o.amt     = instr_i[AMT_LO +: AMT_BITS];
        fields_o.rm      = instr_i[IDX_BITS-1:0];
        fields_o.lit     = instr_i[LIT_BITS-1:0];
        fields_o.up      = instr_i[UP_BIT];
        fields_o.lit_sel = instr_i[IMM_BIT];
    end
endmodule

// File: rtl/shf_core.sv
module shf_core
    import shf_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned AMT_W = $clog2(DATA_W)
) (
    input  shk_e              kind_i,
    input  logic [AMT_W-1:0]  amt_i,
    input  logic [DATA_W-1:0] x_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cout_o,
    output logic              we_o
);
    logic [AMT_W:0]      lsl_idx;
    logic [2*DATA_W-1:0] dbl;
    logic                zero_amt;

    always_comb begin
        zero_amt = (amt_i == '0);
        lsl_idx  = (AMT_W+1)'(DATA_W) - {1'b0, amt_i};
        dbl      = {x_i, x_i} >> amt_i;
        res_o    = x_i;
        cout_o   = cin_i;
        we_o     = 1'b1;
        unique case (kind_i)
            SHK_LSL: begin
                if (zero_amt) begin
                    res_o  = x_i;
                    cout_o = cin_i;
                    we_o   = 1'b0;
                end else begin
                    res_o  = x_i << amt_i;
                    cout_o = x_i[lsl_idx[AMT_W-1:0]];
                end
            end
            SHK_LSR: begin
                if (zero_amt) begin
                    res_o  = '0;
                    cout_o = x_i[DATA_W-1];
                end else begin
                    res_o  = x_i >> amt_i;
                    cout_o = x_i[amt_i - 1'b1];
                end
            end
            SHK_ASR: begin
                if (zero_amt) begin
                    res_o  = {DATA_W{x_i[DATA_W-1]}};
                    cout_o = x_i[DATA_W-1];
                end else begin
                    res_o  = DATA_W'($signed(x_i) >>> amt_i);
                    cout_o = x_i[amt_i - 1'b1];
                end
            end
            SHK_ROR: begin
                if (zero_amt) begin
                    res_o  = {cin_i, x_i[DATA_W-1:1]};
                    cout_o = x_i[0];
                end else begin
                    res_o  = dbl[DATA_W-1:0];
                    cout_o = dbl[DATA_W-1];
                end
            end
            default: begin
                res_o  = x_i;
                cout_o = cin_i;
            end
        endcase
    end
endmodule

// File: rtl/shf_offset.sv
module shf_offset #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LIT_W  = 12
) (
    input  logic [DATA_W-1:0] base_i,
    input  logic [DATA_W-1:0] shifted_i,
    input  logic [LIT_W-1:0]  lit_i,
    input  logic              lit_sel_i,
    input  logic              up_i,
    output logic [DATA_W-1:0] addr_o
);
    logic [DATA_W-1:0] off;

    always_comb begin
        off    = lit_sel_i ? DATA_W'(lit_i) : shifted_i;
        addr_o = up_i ? (base_i + off) : (base_i - off);
    end
endmodule

// File: rtl/shf_operand_unit.sv
module shf_operand_unit
    import shf_pkg::*;
#(
    parameter int unsigned DATA_W     = 32,
    parameter bit          HAS_OFFSET = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       instr_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic              carry_i,
    input  logic [DATA_W-1:0] base_i,
    output logic [DATA_W-1:0] result_o,
    output logic              carry_o,
    output logic              carry_we_o,
    output logic [DATA_W-1:0] addr_o,
    output logic [3:0]        rm_idx_o
);
    localparam int unsigned AMT_W = $clog2(DATA_W);

    typedef struct packed {
        logic [DATA_W-1:0]   res;
        logic                carry;
        logic                we;
        logic [DATA_W-1:0]   addr;
        logic [IDX_BITS-1:0] rm;
    } out_t;

    shf_fields_t       fld;
    logic [DATA_W-1:0] sh_res;
    logic              sh_c;
    logic              sh_we;
    logic [DATA_W-1:0] addr_c;
    out_t              st_d, st_q;

    shf_decode #(.INSN_W(32)) u_dec (
        .instr_i  (instr_i),
        .fields_o (fld)
    );

    shf_core #(.DATA_W(DATA_W)) u_core (
        .kind_i (fld.kind),
        .amt_i  (AMT_W'(fld.amt)),
        .x_i    (operand_i),
        .cin_i  (carry_i),
        .res_o  (sh_res),
        .cout_o (sh_c),
        .we_o   (sh_we)
    );

    generate
        if (HAS_OFFSET) begin : g_off
            shf_offset #(.DATA_W(DATA_W), .LIT_W(LIT_BITS)) u_off (
                .base_i    (base_i),
                .shifted_i (sh_res),
                .lit_i     (fld.lit),
                .lit_sel_i (fld.lit_sel),
                .up_i      (fld.up),
                .addr_o    (addr_c)
            );
        end else begin : g_nooff
            assign addr_c = '0;
        end
    endgenerate

    always_comb begin
        st_d       = st_q;
        st_d.res   = sh_res;
        st_d.carry = sh_c;
        st_d.we    = sh_we;
        st_d.addr  = addr_c;
        st_d.rm    = fld.rm;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o   = st_q.res;
    assign carry_o    = st_q.carry;
    assign carry_we_o = st_q.we;
    assign addr_o     = st_q.addr;
    assign rm_idx_o   = st_q.rm;
endmodule

// File: rtl/shf_operand_chk.sv
module shf_operand_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [31:0]       instr_i,
    input logic [DATA_W-1:0] operand_i,
    input logic              carry_i,
    input logic [DATA_W-1:0] base_i,
    input logic [DATA_W-1:0] result_o,
    input logic              carry_o,
    input logic              carry_we_o,
    input logic [DATA_W-1:0] addr_o,
    input logic [3:0]        rm_idx_o
);
    logic [DATA_W-1:0] unused_base;
    assign unused_base = base_i;

    AST_LSL_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(instr_i[11:5]) == 7'd0)
        |-> (result_o == $past(operand_i) && carry_o == $past(carry_i) && !carry_we_o)); // R4

    AST_LSR_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(instr_i[11:5]) == 7'd1)
        |-> (result_o == '0 && carry_o == $past(operand_i[DATA_W-1]))); // R5

    AST_ASR_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(instr_i[11:5]) == 7'd2)
        |-> ($countones(result_o ^ {DATA_W{$past(operand_i[DATA_W-1])}}) == 0
             && carry_o == $past(operand_i[DATA_W-1]))); // R6

    AST_RRX: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(instr_i[11:5]) == 7'd3)
        |-> (result_o[DATA_W-1] == $past(carry_i) && carry_o == $past(operand_i[0])
             && result_o[DATA_W-2:0] == $past(operand_i[DATA_W-1:1]))); // R7

    AST_WE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(instr_i[11:5]) != 7'd0) |-> carry_we_o); // R8

    AST_ADDR_REG_UP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(instr_i[25]) == 1'b0 && $past(instr_i[23]))
        |-> (addr_o == $past(base_i) + result_o)); // R9

    AST_IDX_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rm_idx_o == $past(instr_i[3:0]))); // R1

    always_comb begin
        if (!rst_n) begin
            AST_RESET_CLEAR: assert (result_o == '0 && addr_o == '0 && !carry_o && !carry_we_o); // R10
        end
    end
endmodule

bind shf_operand_unit shf_operand_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .instr_i    (instr_i),
    .operand_i  (operand_i),
    .carry_i    (carry_i),
    .base_i     (base_i),
    .result_o   (result_o),
    .carry_o    (carry_o),
    .carry_we_o (carry_we_o),
    .addr_o     (addr_o),
    .rm_idx_o   (rm_idx_o)
);

// File: tb/sim_shf_operand_unit.sv
module sim_shf_operand_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr_i = '0;
    logic [31:0] operand_i = '0;
    logic        carry_i = 1'b0;
    logic [31:0] base_i = '0;
    logic [31:0] result_o;
    logic        carry_o;
    logic        carry_we_o;
    logic [31:0] addr_o;
    logic [3:0]  rm_idx_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shf_operand_unit u0 (
        .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .operand_i(operand_i),
        .carry_i(carry_i), .base_i(base_i), .result_o(result_o), .carry_o(carry_o),
        .carry_we_o(carry_we_o), .addr_o(addr_o), .rm_idx_o(rm_idx_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [1:0] ty, input logic [4:0] amt,
                                       input logic [3:0] rm, input logic lit, input logic up);
        logic [31:0] w;
        w = 32'h0;
        w[3:0]  = rm;
        w[6:5]  = ty;
        w[11:7] = amt;
        w[23]   = up;
        w[25]   = lit;
        return w;
    endfunction

    // Independent reference written from the requirements
    task automatic model(input logic [31:0] ins, input logic [31:0] x, input logic cin,
                         input logic [31:0] base, output logic [31:0] r, output logic c,
                         output logic we, output logic [31:0] a);
        int n;
        logic [31:0] off;
        n  = int'(ins[11:7]);
        we = 1'b1;
        r  = '0;
        c  = 1'b0;
        case (ins[6:5])
            2'd0: if (n == 0) begin r = x; c = cin; we = 1'b0; end
                  else begin
                      for (int i = 0; i < 32; i++) r[i] = (i >= n) ? x[i-n] : 1'b0;
                      c = x[32-n];
                  end
            2'd1: if (n == 0) begin r = '0; c = x[31]; end
                  else begin
                      for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? x[i+n] : 1'b0;
                      c = x[n-1];
                  end
            2'd2: if (n == 0) begin r = x[31] ? 32'hFFFF_FFFF : 32'h0; c = x[31]; end
                  else begin
                      for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? x[i+n] : x[31];
                      c = x[n-1];
                  end
            default: if (n == 0) begin
                      for (int i = 0; i < 31; i++) r[i] = x[i+1];
                      r[31] = cin; c = x[0];
                  end else begin
                      for (int i = 0; i < 32; i++) r[i] = x[(i + n) % 32];
                      c = r[31];
                  end
        endcase
        off = ins[25] ? {20'h0, ins[11:0]} : r;
        a   = ins[23] ? base + off : base - off;
    endtask

    task automatic apply(input string tag, input logic [31:0] ins, input logic [31:0] x,
                         input logic cin, input logic [31:0] base);
        logic [31:0] er, ea;
        logic ec, ew;
        @(negedge clk);
        instr_i = ins; operand_i = x; carry_i = cin; base_i = base;
        model(ins, x, cin, base, er, ec, ew, ea);
        @(negedge clk);
        chk({tag, " result"}, result_o, er);
        chk({tag, " carry"}, {31'h0, carry_o}, {31'h0, ec});
        chk({tag, " carry_we"}, {31'h0, carry_we_o}, {31'h0, ew});
        chk({tag, " addr"}, addr_o, ea);
        chk({tag, " R1 idx"}, {28'h0, rm_idx_o}, {28'h0, ins[3:0]});
    endtask

    task automatic t_reset();
        @(negedge clk);
        instr_i = mk(2'd3, 5'd4, 4'hA, 1'b0, 1'b1); operand_i = 32'hDEAD_BEEF;
        carry_i = 1'b1; base_i = 32'h100;
        @(negedge clk);
        chk("R10 reset result", result_o, 32'h0);
        chk("R10 reset addr", addr_o, 32'h0);
        chk("R10 reset flags", {30'h0, carry_o, carry_we_o}, 32'h0);
        chk("R10 reset idx", {28'h0, rm_idx_o}, 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_nonzero();
        apply("R2 R3 lsl 1", mk(2'd0, 5'd1, 4'h3, 1'b0, 1'b1), 32'h8000_0001, 1'b0, 32'h0);
        apply("R2 R3 lsl 31", mk(2'd0, 5'd31, 4'h5, 1'b0, 1'b1), 32'h0000_0003, 1'b0, 32'h10);
        apply("R2 R3 lsr 4", mk(2'd1, 5'd4, 4'h1, 1'b0, 1'b1), 32'hF000_0018, 1'b1, 32'h0);
        apply("R2 R3 lsr 31", mk(2'd1, 5'd31, 4'h2, 1'b0, 1'b1), 32'hC000_0000, 1'b0, 32'h0);
        apply("R2 R3 asr 8", mk(2'd2, 5'd8, 4'h7, 1'b0, 1'b1), 32'h8123_4580, 1'b0, 32'h0);
        apply("R2 R3 asr 3 pos", mk(2'd2, 5'd3, 4'h8, 1'b0, 1'b1), 32'h7000_0004, 1'b0, 32'h0);
        apply("R2 R3 ror 8", mk(2'd3, 5'd8, 4'h9, 1'b0, 1'b1), 32'h1234_5680, 1'b0, 32'h0);
        apply("R2 R3 ror 1", mk(2'd3, 5'd1, 4'hF, 1'b0, 1'b1), 32'h0000_0001, 1'b0, 32'h0);
    endtask

    task automatic t_zero();
        apply("R4 lsl 0 cin1", mk(2'd0, 5'd0, 4'h4, 1'b0, 1'b1), 32'hCAFE_F00D, 1'b1, 32'h0);
        apply("R4 lsl 0 cin0", mk(2'd0, 5'd0, 4'h4, 1'b0, 1'b1), 32'hCAFE_F00D, 1'b0, 32'h0);
        apply("R5 lsr 0", mk(2'd1, 5'd0, 4'h6, 1'b0, 1'b1), 32'h8000_0000, 1'b0, 32'h40);
        apply("R6 asr 0 neg", mk(2'd2, 5'd0, 4'h6, 1'b0, 1'b1), 32'h8000_0000, 1'b0, 32'h0);
        apply("R6 asr 0 pos", mk(2'd2, 5'd0, 4'h6, 1'b0, 1'b1), 32'h7FFF_FFFF, 1'b1, 32'h0);
        apply("R7 rrx cin1", mk(2'd3, 5'd0, 4'hB, 1'b0, 1'b1), 32'h0000_0003, 1'b1, 32'h0);
        apply("R7 rrx cin0", mk(2'd3, 5'd0, 4'hB, 1'b0, 1'b1), 32'hFFFF_FFFE, 1'b0, 32'h0);
    endtask

    task automatic t_offset();
        apply("R9 reg up", mk(2'd0, 5'd2, 4'h1, 1'b0, 1'b1), 32'h0000_0010, 1'b0, 32'h1000);
        apply("R9 reg down", mk(2'd1, 5'd1, 4'h1, 1'b0, 1'b0), 32'h0000_0020, 1'b0, 32'h1000);
        apply("R9 lit up", mk(2'd2, 5'd9, 4'hC, 1'b1, 1'b1), 32'hFFFF_FFFF, 1'b0, 32'h2000);
        apply("R9 lit down", mk(2'd3, 5'd1, 4'hD, 1'b1, 1'b0), 32'h0, 1'b1, 32'h0000_0010);
    endtask

    task automatic t_sweep();
        for (int k = 0; k < 4; k++) begin
            for (int a = 0; a < 32; a += 5) begin
                apply("R1 R8 sweep", mk(2'(k), 5'(a), 4'(a), 1'b0, 1'(a & 1)),
                      32'h9E37_79B9 ^ (32'(a) << 11), 1'(k & 1), 32'h8000);
            end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_nonzero();
        t_zero();
        t_offset();
        t_sweep();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog got=timeout exp=completion");
        finish_run();
    end
endmodule